// File: doc/BRIEF.md
# I2C Pin Override Unit

This block sits between an I2C protocol engine and the two open-drain bus pins, SCL and SDA. In normal operation the protocol engine decides when each line is pulled low. When software needs to free a stuck bus, it sets a single ownership bit, and both pins then move together to a software-controlled path. On that path each pin has a direction bit and an output latch, and a synchronised level register lets software watch the real line state while it toggles the clock.

Software changes the output latch through write-one-to-set and write-one-to-clear addresses, so it never needs a read-modify-write. A combined update address carries a set mask and a clear mask in one write. When both masks name the same bit, clearing takes priority. The pins are emulated open drain: a line is only ever pulled low or released, never driven high.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset the ownership bit, both direction bits and both latch bits read 0, and each pin's pull-low output follows the protocol engine's request for that pin.
- R2: While the ownership bit (address 0, bit 0) is 0, `scl_pull` equals `eng_scl_pull` and `sda_pull` equals `eng_sda_pull`, whatever the direction and latch bits hold.
- R3: While the ownership bit is 1, the engine requests have no effect. A pin is pulled low only when its direction bit (address 1; bit 0 is SCL, bit 1 is SDA) is 1 and its latch bit is 0. In every other case the pin is released.
- R4: A write to the set address (3) sets each latch bit whose write-data bit is 1 (bit 0 SCL, bit 1 SDA) and leaves the other latch bits alone. Reading address 3, 4 or 5 returns the latch in bits [1:0].
- R5: A write to the clear address (4) clears each latch bit whose write-data bit is 1 and leaves the other latch bits alone.
- R6: A write to the update address (5) uses write-data bits [1:0] as a set mask and bits [3:2] as a clear mask. A bit named in both masks ends up 0.
- R7: The level register (address 2) shows SCL in bit 0 and SDA in bit 1, as the pins stood two clock edges before the read.
- R8: Writes to the level address or to an unmapped address (6, 7) leave the ownership, direction and latch state unchanged. Unmapped addresses read 0.
- R9: A write to the ownership or direction address takes effect at the clock edge that accepts the write, and the value reads back from the same address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data, combinational from `reg_addr` |
| eng_scl_pull | input | 1 | Protocol engine request to pull SCL low |
| eng_sda_pull | input | 1 | Protocol engine request to pull SDA low |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | Pull-low enable for the SCL pad |
| sda_pull | output | 1 | Pull-low enable for the SDA pad |

## Verification
Register writes update state at the accepting edge. The pad outputs and the read data are combinational from that state, so the bench drives inputs on the falling edge and reads results at the next falling edge, one cycle after the write. A change on a sensed pin needs two rising edges before it appears in the level register. The bench therefore changes a pin at a falling edge and checks that the old level still reads after one rising edge and the new level reads after the second. Pad outputs under engine ownership are combinational from the engine inputs and are checked a short settle time after the inputs change, with no clock edge in between.

// File: rtl/i2c_ovr_pkg.sv
package i2c_ovr_pkg;

  localparam int OVR_ADDR_W = 3;

  // register address map of the override unit
  typedef enum logic [OVR_ADDR_W-1:0] {
    OVR_SEL   = 3'd0,  // pin ownership, bit 0
    OVR_DIR   = 3'd1,  // per-pin direction, 1 = output
    OVR_LEVEL = 3'd2,  // synchronised pin levels, read only
    OVR_SET   = 3'd3,  // write ones to set latch bits
    OVR_CLR   = 3'd4,  // write ones to clear latch bits
    OVR_UPD   = 3'd5   // set mask low half, clear mask high half
  } ovr_addr_e;

endpackage

// File: rtl/i2c_ovr_rst_sync.sv
module i2c_ovr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_ovr_sync.sv
module i2c_ovr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_nxt;

  always_comb begin
    stage_nxt[0] = d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb begin
      stage_nxt[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
    end
  end

  assign q = stage_q[STAGES-1];

  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stage_q[0] == $past(d))); // R7

endmodule

// File: rtl/i2c_ovr_regs.sv
module i2c_ovr_regs
  import i2c_ovr_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int DATA_W   = 2 * NUM_PINS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [OVR_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_PINS-1:0]   level,
  output logic [DATA_W-1:0]     rdata,
  output logic                  sel,
  output logic [NUM_PINS-1:0]   dir,
  output logic [NUM_PINS-1:0]   latch
);

  logic                sel_q, sel_nxt, sel_en;
  logic [NUM_PINS-1:0] dir_q, dir_nxt;
  logic                dir_en;
  logic [NUM_PINS-1:0] latch_q, latch_nxt;
  logic                latch_en;
  logic [NUM_PINS-1:0] set_mask, clr_mask;
  logic                wr_set, wr_clr, wr_upd;

  // write decode and next state
  always_comb begin
    sel_en  = we && (addr == OVR_SEL);
    dir_en  = we && (addr == OVR_DIR);
    wr_set  = we && (addr == OVR_SET);
    wr_clr  = we && (addr == OVR_CLR);
    wr_upd  = we && (addr == OVR_UPD);
    sel_nxt = wdata[0];
    dir_nxt = wdata[NUM_PINS-1:0];

    set_mask = '0;
    clr_mask = '0;
    if (wr_set) set_mask = wdata[NUM_PINS-1:0];
    if (wr_clr) clr_mask = wdata[NUM_PINS-1:0];
    if (wr_upd) begin
      set_mask = wdata[NUM_PINS-1:0];
      clr_mask = wdata[2*NUM_PINS-1:NUM_PINS];
    end
    latch_en  = wr_set || wr_clr || wr_upd;
    // clear is applied after set, so it wins on a shared bit
    latch_nxt = (latch_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (sel_en)   sel_q   <= sel_nxt;
      if (dir_en)   dir_q   <= dir_nxt;
      if (latch_en) latch_q <= latch_nxt;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      OVR_SEL:   rdata[0] = sel_q;
      OVR_DIR:   rdata[NUM_PINS-1:0] = dir_q;
      OVR_LEVEL: rdata[NUM_PINS-1:0] = level;
      OVR_SET,
      OVR_CLR,
      OVR_UPD:   rdata[NUM_PINS-1:0] = latch_q;
      default:   rdata = '0;
    endcase
  end

  assign sel   = sel_q;
  assign dir   = dir_q;
  assign latch = latch_q;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OVR_SET) |=>
      ((latch_q & $past(wdata[NUM_PINS-1:0])) == $past(wdata[NUM_PINS-1:0]))); // R4

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OVR_CLR) |=>
      ((latch_q & $past(wdata[NUM_PINS-1:0])) == '0)); // R5

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OVR_UPD) |=>
      ((latch_q & $past(wdata[2*NUM_PINS-1:NUM_PINS])) == '0)); // R6

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (addr == OVR_SET || addr == OVR_CLR || addr == OVR_UPD)) |=>
      $stable(latch_q)); // R4

  AST_LEVEL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr == OVR_LEVEL || addr > OVR_UPD)) |=>
      ($stable(sel_q) && $stable(dir_q) && $stable(latch_q))); // R8

  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OVR_SEL) |=> (sel_q == $past(wdata[0]))); // R9

endmodule

// File: rtl/i2c_ovr_pad_mux.sv
module i2c_ovr_pad_mux (
  input  logic sel,
  input  logic dir,
  input  logic latch,
  input  logic eng_pull,
  output logic pull
);

  logic sw_pull;

  always_comb begin
    // open-drain emulation: only a low latch on an output pulls the line
    sw_pull = dir && !latch;
    pull    = sel ? sw_pull : eng_pull;
  end

endmodule

// File: rtl/i2c_pin_override.sv
module i2c_pin_override
  import i2c_ovr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [OVR_ADDR_W-1:0] reg_addr,
  input  logic [3:0]            reg_wdata,
  output logic [3:0]            reg_rdata,
  input  logic                  eng_scl_pull,
  input  logic                  eng_sda_pull,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  scl_pull,
  output logic                  sda_pull
);

  localparam int NUM_PINS = 2;           // index 0 = SCL, 1 = SDA
  localparam int DATA_W   = 2 * NUM_PINS;

  logic                rst_n_int;
  logic                own_sw;
  logic [NUM_PINS-1:0] dir_v, latch_v, eng_v, pin_v, level_v, pull_v;

  assign eng_v = {eng_sda_pull, eng_scl_pull};
  assign pin_v = {sda_in, scl_in};

  i2c_ovr_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  i2c_ovr_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) i_regs (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .level (level_v),
    .rdata (reg_rdata),
    .sel   (own_sw),
    .dir   (dir_v),
    .latch (latch_v)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    i2c_ovr_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n_int),
      .d     (pin_v[p]),
      .q     (level_v[p])
    );

    i2c_ovr_pad_mux i_mux (
      .sel      (own_sw),
      .dir      (dir_v[p]),
      .latch    (latch_v[p]),
      .eng_pull (eng_v[p]),
      .pull     (pull_v[p])
    );
  end

  assign scl_pull = pull_v[0];
  assign sda_pull = pull_v[1];

  AST_ENGINE_OWNS: assert property (@(posedge clk) disable iff (!rst_n_int)
    !own_sw |-> ({sda_pull, scl_pull} == {eng_sda_pull, eng_scl_pull})); // R2

  AST_RELEASED_INPUT: assert property (@(posedge clk) disable iff (!rst_n_int)
    own_sw |-> (({sda_pull, scl_pull} & ~dir_v) == '0)); // R3

endmodule

// File: tb/test_i2c_pin_override.sv
module test_i2c_pin_override;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_addr;
  logic [3:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic       eng_scl_pull, eng_sda_pull;
  logic       scl_in, sda_in;
  logic       scl_pull, sda_pull;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_pin_override i_i2c_pin_override (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .eng_scl_pull (eng_scl_pull),
    .eng_sda_pull (eng_sda_pull),
    .scl_in       (scl_in),
    .sda_in       (sda_in),
    .scl_pull     (scl_pull),
    .sda_pull     (sda_pull)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [3:0] pulls();
    return {2'b00, sda_pull, scl_pull};
  endfunction

  task automatic t_reset;
    logic [3:0] v;
    rd(3'd0, v); check("R1 sel", v, 4'h0);
    rd(3'd1, v); check("R1 dir", v, 4'h0);
    rd(3'd3, v); check("R1 latch", v, 4'h0);
    eng_scl_pull = 1'b1; eng_sda_pull = 1'b0; #1;
    check("R1 pins follow engine", pulls(), 4'h1);
    eng_scl_pull = 1'b0; eng_sda_pull = 1'b1; #1;
    check("R1 pins follow engine", pulls(), 4'h2);
  endtask

  task automatic t_engine_owns;
    logic [3:0] v;
    wr(3'd1, 4'h3);            // both outputs, latch still 0
    rd(3'd1, v); check("R9 dir readback", v, 4'h3);
    eng_scl_pull = 1'b0; eng_sda_pull = 1'b0; #1;
    check("R2 engine release wins over sw", pulls(), 4'h0);
    eng_scl_pull = 1'b1; eng_sda_pull = 1'b1; #1;
    check("R2 engine pull", pulls(), 4'h3);
  endtask

  task automatic t_sw_owns;
    logic [3:0] v;
    wr(3'd0, 4'h1);
    rd(3'd0, v); check("R9 sel readback", v, 4'h1);
    eng_scl_pull = 1'b0; eng_sda_pull = 1'b0; #1;
    check("R3 dir out latch 0 pulls", pulls(), 4'h3);
    wr(3'd1, 4'h2);            // SCL input, SDA output
    check("R3 input pin released", pulls(), 4'h2);
    eng_scl_pull = 1'b1; #1;
    check("R3 engine ignored", pulls(), 4'h2);
    eng_scl_pull = 1'b0;
    wr(3'd1, 4'h3);
  endtask

  task automatic t_set_clear;
    logic [3:0] v;
    wr(3'd3, 4'h1);            // set SCL only
    rd(3'd3, v); check("R4 set SCL", v, 4'h1);
    check("R4 SCL released SDA pulled", pulls(), 4'h2);
    wr(3'd3, 4'h0);            // zero bits: no effect
    rd(3'd4, v); check("R4 zero set no effect", v, 4'h1);
    wr(3'd3, 4'h2);
    rd(3'd5, v); check("R4 set SDA keeps SCL", v, 4'h3);
    check("R3 both released", pulls(), 4'h0);
    wr(3'd4, 4'h0);
    rd(3'd3, v); check("R5 zero clear no effect", v, 4'h3);
    wr(3'd4, 4'h1);
    rd(3'd3, v); check("R5 clear SCL", v, 4'h2);
    check("R5 SCL pulled", pulls(), 4'h1);
    wr(3'd1, 4'h1);            // SDA back to input
    check("R3 latch 1 on input stays released", pulls(), 4'h1);
    wr(3'd1, 4'h3);
  endtask

  task automatic t_update;
    logic [3:0] v;
    wr(3'd5, 4'b1101);         // set SCL; clear SCL and SDA
    rd(3'd5, v); check("R6 clear wins", v, 4'h0);
    wr(3'd5, 4'b0011);
    rd(3'd5, v); check("R6 set both", v, 4'h3);
    wr(3'd5, 4'b1001);         // set SCL, clear SDA
    rd(3'd5, v); check("R6 mixed", v, 4'h1);
  endtask

  task automatic t_level;
    logic [3:0] v;
    scl_in = 1'b1; sda_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd2, v); check("R7 level idle", v, 4'h3);
    scl_in = 1'b0;             // changed at a falling edge
    @(negedge clk);
    rd(3'd2, v); check("R7 one edge later old", v, 4'h3);
    @(negedge clk);
    rd(3'd2, v); check("R7 two edges later new", v, 4'h2);
    sda_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd(3'd2, v); check("R7 SDA bit 1", v, 4'h0);
    scl_in = 1'b1; sda_in = 1'b1;
  endtask

  task automatic t_ignored;
    logic [3:0] v;
    wr(3'd2, 4'hF);
    wr(3'd6, 4'hF);
    wr(3'd7, 4'hF);
    rd(3'd0, v); check("R8 sel unchanged", v, 4'h1);
    rd(3'd1, v); check("R8 dir unchanged", v, 4'h3);
    rd(3'd3, v); check("R8 latch unchanged", v, 4'h1);
    rd(3'd6, v); check("R8 unmapped reads 0", v, 4'h0);
    wr(3'd0, 4'h0);            // return ownership
    eng_scl_pull = 1'b0; eng_sda_pull = 1'b1; #1;
    check("R2 engine back", pulls(), 4'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    eng_scl_pull = 1'b0; eng_sda_pull = 1'b0;
    scl_in = 1'b1; sda_in = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_engine_owns();
    t_sw_owns();
    t_set_clear();
    t_update();
    t_level();
    t_ignored();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule